// File: doc/BRIEF.md
# Partitioned Saturating SIMD Adder

This block adds or subtracts two 64-bit operands that are split into independent lanes. A two-bit lane selector makes the word eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane. Carries never pass from one lane into the next, so one operation handles several packed media elements at once, such as the colour and alpha bytes of a pixel.

Each operation takes one of three arithmetic modes. Wraparound keeps the low bits of each lane. Signed saturation clamps a lane that overflows to the most positive or most negative value of the lane width. Unsigned saturation clamps to all ones on an add overflow and to zero on a subtract underflow. For every lane that was clamped, a flag bit is raised. The result and the flags are registered, and they appear one cycle after a valid input.

Top module: `simd_sat_adder`

## Requirements
- R1: The lane selector `lane_i` sets the lane width: 2'b00 gives 8 bits, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 64. Lane k occupies result bits [k*w +: w]. No carry or borrow passes between lanes.
- R2: When `sub_i` is 1, each lane computes a minus b. When `sub_i` is 0, each lane computes a plus b.
- R3: With `mode_i` at 2'b00 (wrap), or at the spare code 2'b11, which also wraps, each lane returns its true result modulo 2^w and every flag is 0.
- R4: With `mode_i` at 2'b01 (signed saturation), a lane whose two's-complement result is above the maximum returns 0 followed by all ones. A lane whose result is below the minimum returns 1 followed by all zeros.
- R5: With `mode_i` at 2'b10 (unsigned saturation), an add that exceeds 2^w-1 returns all ones. A subtract with a < b returns zero.
- R6: Flag bit k of `sat_o` is 1 exactly when lane k was clamped. Flag bits at or above the lane count are 0.
- R7: `valid_o` follows `valid_i` with one cycle of latency. `result_o` and `sat_o` update only on a cycle with `valid_i` high, and otherwise hold their values.
- R8: After a synchronous reset, `valid_o`, `result_o` and `sat_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operands and controls are valid this cycle |
| a_i | input | 64 | Operand a |
| b_i | input | 64 | Operand b |
| lane_i | input | 2 | Lane width selector |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| mode_i | input | 2 | Arithmetic mode: wrap, signed saturate, unsigned saturate |
| valid_o | output | 1 | Result valid |
| result_o | output | 64 | Registered lane results |
| sat_o | output | 8 | Per-lane clamp flags |

## Verification
The assertions assume that all control inputs are known, 2-state values in any cycle where `valid_i` is high. They also assume that `rst` is held for at least one edge before the first operation. The bench drives every input from its tasks on the falling edge, starting with reset and never leaving a control input undriven. It sets the operands to each lane's extreme values so that every clamp direction occurs in every lane width. Cases where `valid_i` is low pair fresh operands with an unchanged output, to show that the stored result holds.

// File: rtl/psa_pkg.sv
package psa_pkg;

    typedef enum logic [1:0] {
        LANE_8  = 2'b00,
        LANE_16 = 2'b01,
        LANE_32 = 2'b10,
        LANE_64 = 2'b11
    } lane_e;

    typedef enum logic [1:0] {
        ARITH_WRAP = 2'b00,
        ARITH_SSAT = 2'b01,
        ARITH_USAT = 2'b10,
        ARITH_RSVD = 2'b11
    } arith_e;

    // clamp decision made at the top slice of a lane
    typedef struct packed {
        logic active;   // lane result must be replaced
        logic to_high;  // 1: clamp to maximum, 0: clamp to minimum
    } clamp_t;

    function automatic int lane_slices(input lane_e l);
        return 1 << l;
    endfunction

    function automatic logic is_lane_bottom(input int idx, input lane_e l);
        return (idx & (lane_slices(l) - 1)) == 0;
    endfunction

    function automatic int lane_top_of(input int idx, input lane_e l);
        return idx | (lane_slices(l) - 1);
    endfunction

endpackage

// File: rtl/psa_slice.sv
module psa_slice #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         invert_b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         c_msb,
    output logic         cout
);
    logic [W-1:0] b_eff;
    logic [W-2:0] low;
    logic         top;

    always_comb begin
        b_eff        = b ^ {W{invert_b}};
        {c_msb, low} = {1'b0, a[W-2:0]} + {1'b0, b_eff[W-2:0]} + {{(W-1){1'b0}}, cin};
        {cout, top}  = {1'b0, a[W-1]} + {1'b0, b_eff[W-1]} + {1'b0, c_msb};
        sum          = {top, low};
    end
endmodule

// File: rtl/psa_sat_detect.sv
module psa_sat_detect
    import psa_pkg::*;
(
    input  arith_e  mode,
    input  logic    sub,
    input  logic    a_msb,
    input  logic    c_msb,
    input  logic    cout,
    output clamp_t  decision
);
    always_comb begin
        decision = '0;
        unique case (mode)
            ARITH_SSAT: begin
                decision.active  = c_msb ^ cout;
                decision.to_high = ~a_msb;
            end
            ARITH_USAT: begin
                decision.active  = sub ? ~cout : cout;
                decision.to_high = ~sub;
            end
            default: decision = '0;
        endcase
    end
endmodule

// File: rtl/psa_clamp_mux.sv
module psa_clamp_mux
    import psa_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] sum,
    input  clamp_t       decision,
    input  logic         signed_mode,
    input  logic         is_top,
    output logic [W-1:0] out
);
    logic [W-1:0] hi_val, lo_val;

    always_comb begin
        hi_val = '1;
        lo_val = '0;
        if (signed_mode && is_top) begin
            hi_val = {1'b0, {(W-1){1'b1}}};
            lo_val = {1'b1, {(W-1){1'b0}}};
        end
        if (!decision.active) out = sum;
        else if (decision.to_high) out = hi_val;
        else out = lo_val;
    end
endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
    import psa_pkg::*;
#(
    parameter int SLICE_W    = 8,
    parameter int NUM_SLICES = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          valid_i,
    input  logic [SLICE_W*NUM_SLICES-1:0] a_i,
    input  logic [SLICE_W*NUM_SLICES-1:0] b_i,
    input  logic [1:0]                    lane_i,
    input  logic                          sub_i,
    input  logic [1:0]                    mode_i,
    output logic                          valid_o,
    output logic [SLICE_W*NUM_SLICES-1:0] result_o,
    output logic [NUM_SLICES-1:0]         sat_o
);
    localparam int DATA_W = SLICE_W * NUM_SLICES;

    lane_e  lane;
    arith_e mode;
    assign lane = lane_e'(lane_i);
    assign mode = arith_e'(mode_i);

    logic [NUM_SLICES-1:0]  cin, c_msb, cout;
    logic [SLICE_W-1:0]     sums  [NUM_SLICES];
    clamp_t                 dec   [NUM_SLICES];
    clamp_t                 dec_sel [NUM_SLICES];
    logic [NUM_SLICES-1:0]  is_top;
    logic [DATA_W-1:0]      next_result;
    logic [NUM_SLICES-1:0]  next_sat;

    // carry chain, broken at each lane bottom where the subtract carry enters
    always_comb begin
        for (int i = 0; i < NUM_SLICES; i++) begin
            if (i == 0 || is_lane_bottom(i, lane)) cin[i] = sub_i;
            else cin[i] = cout[(i > 0) ? i-1 : 0];
            is_top[i]  = (lane_top_of(i, lane) == i);
            dec_sel[i] = dec[lane_top_of(i, lane) % NUM_SLICES];
        end
    end

    for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
        psa_slice #(.W(SLICE_W)) u_slice (
            .a        (a_i[g*SLICE_W +: SLICE_W]),
            .b        (b_i[g*SLICE_W +: SLICE_W]),
            .invert_b (sub_i),
            .cin      (cin[g]),
            .sum      (sums[g]),
            .c_msb    (c_msb[g]),
            .cout     (cout[g])
        );

        psa_sat_detect u_detect (
            .mode     (mode),
            .sub      (sub_i),
            .a_msb    (a_i[g*SLICE_W + SLICE_W-1]),
            .c_msb    (c_msb[g]),
            .cout     (cout[g]),
            .decision (dec[g])
        );

        psa_clamp_mux #(.W(SLICE_W)) u_clamp (
            .sum         (sums[g]),
            .decision    (dec_sel[g]),
            .signed_mode (mode == ARITH_SSAT),
            .is_top      (is_top[g]),
            .out         (next_result[g*SLICE_W +: SLICE_W])
        );
    end

    // flags packed by lane index; bits beyond the lane count stay zero
    always_comb begin
        next_sat = '0;
        for (int k = 0; k < NUM_SLICES; k++) begin
            if (k < (NUM_SLICES >> lane))
                next_sat[k] = dec[(k * lane_slices(lane) + lane_slices(lane) - 1) % NUM_SLICES].active;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o  <= 1'b0;
            result_o <= '0;
            sat_o    <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                result_o <= next_result;
                sat_o    <= next_sat;
            end
        end
    end

    // R7: one-cycle latency and hold
    a_r7_latency: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> valid_o);
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(result_o) && $stable(sat_o) && !valid_o));
    // R3: wraparound raises no flag
    a_r3_no_flags: assert property (@(posedge clk) disable iff (rst)
        (valid_i && (mode_i == 2'b00 || mode_i == 2'b11)) |=> (sat_o == '0));
    // R6: unused flag bits in the widest mode
    a_r6_unused_zero: assert property (@(posedge clk) disable iff (rst)
        (valid_i && lane_i == 2'b11) |=> (sat_o[NUM_SLICES-1:1] == '0));
    // R5: full-width unsigned borrow clamps to zero
    a_r5_usub_zero: assert property (@(posedge clk) disable iff (rst)
        (valid_i && lane_i == 2'b11 && mode_i == 2'b10 && sub_i && (a_i < b_i))
        |=> (result_o == '0 && sat_o[0]));
endmodule

// File: tb/simd_sat_adder_test.sv
module simd_sat_adder_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [63:0] a_i, b_i;
    logic [1:0]  lane_i;
    logic        sub_i;
    logic [1:0]  mode_i;
    logic        valid_o;
    logic [63:0] result_o;
    logic [7:0]  sat_o;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    simd_sat_adder uut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
        .lane_i(lane_i), .sub_i(sub_i), .mode_i(mode_i),
        .valid_o(valid_o), .result_o(result_o), .sat_o(sat_o)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                  input logic [1:0] ls, input logic sub, input logic [1:0] md,
                                  output logic [63:0] r, output logic [7:0] f);
        int w, n;
        w = 8 << ls;
        n = 8 >> ls;
        r = '0;
        f = '0;
        for (int k = 0; k < n; k++) begin
            logic [63:0] msk, lane_r;
            logic [64:0] ux, uy, us;
            logic signed [65:0] sx, sy, ss, mx, mn;
            logic ov;
            msk = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
            ux = {1'b0, (a >> (k*w)) & msk};
            uy = {1'b0, (b >> (k*w)) & msk};
            us = sub ? ux - uy : ux + uy;
            lane_r = us[63:0] & msk;
            ov = 1'b0;
            if (md == 2'b01) begin
                sx = $signed({1'b0, ux});
                sy = $signed({1'b0, uy});
                if (ux[w-1]) sx = sx - (66'sd1 <<< w);
                if (uy[w-1]) sy = sy - (66'sd1 <<< w);
                ss = sub ? sx - sy : sx + sy;
                mx = (66'sd1 <<< (w-1)) - 66'sd1;
                mn = -(66'sd1 <<< (w-1));
                if (ss > mx) begin lane_r = mx[63:0] & msk; ov = 1'b1; end
                else if (ss < mn) begin lane_r = mn[63:0] & msk; ov = 1'b1; end
            end else if (md == 2'b10) begin
                if (!sub && us > {1'b0, msk}) begin lane_r = msk; ov = 1'b1; end
                else if (sub && ux < uy) begin lane_r = '0; ov = 1'b1; end
            end
            r = r | (lane_r << (k*w));
            f[k] = ov;
        end
    endfunction

    task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic [1:0] ls,
                          input logic sub, input logic [1:0] md, input string req);
        logic [63:0] er;
        logic [7:0]  ef;
        model(a, b, ls, sub, md, er, ef);
        @(negedge clk);
        a_i = a; b_i = b; lane_i = ls; sub_i = sub; mode_i = md; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        check({req, " valid (R7)"}, {63'd0, valid_o}, 64'd1);
        check({req, " result"}, result_o, er);
        check({req, " flags (R6)"}, {56'd0, sat_o}, {56'd0, ef});
    endtask

    task automatic t_reset;
        rst = 1'b1; valid_i = 1'b0; a_i = '0; b_i = '0;
        lane_i = 2'b00; sub_i = 1'b0; mode_i = 2'b00;
        repeat (2) @(negedge clk);
        check("R8 valid", {63'd0, valid_o}, 64'd0);
        check("R8 result", result_o, 64'd0);
        check("R8 flags", {56'd0, sat_o}, 64'd0);
        rst = 1'b0;
    endtask

    task automatic t_wrap_lanes;
        // R1 R3: carries must stop at every lane edge
        run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'b00, 1'b0, 2'b00, "R1 R3 wrap8");
        run_op(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'b01, 1'b0, 2'b00, "R1 wrap16");
        run_op(64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF, 2'b10, 1'b0, 2'b00, "R1 wrap32");
        run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0002, 2'b11, 1'b0, 2'b11, "R3 spare code wraps");
    endtask

    task automatic t_subtract;
        run_op(64'h0010_2030_4050_6070, 64'h0102_0304_0506_0708, 2'b00, 1'b1, 2'b00, "R2 sub8");
        run_op(64'h0000_0000_0000_0000, 64'h0001_0001_0001_0001, 2'b01, 1'b1, 2'b00, "R2 R3 sub16 borrow");
    endtask

    task automatic t_signed;
        run_op(64'h7F80_7F80_0102_7F80, 64'h0101_FFFF_0102_80FF, 2'b00, 1'b0, 2'b01, "R4 ssat8");
        run_op(64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF, 2'b10, 1'b1, 2'b01, "R4 ssat32 sub");
        run_op(64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b11, 1'b0, 2'b01, "R4 ssat64 pos");
        run_op(64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001, 2'b11, 1'b1, 2'b01, "R4 ssat64 neg");
    endtask

    task automatic t_unsigned;
        run_op(64'hFFFF_0001_8000_1234, 64'h0001_0001_8000_0000, 2'b01, 1'b0, 2'b10, "R5 R6 usat16 add");
        run_op(64'h0005_0010_0000_FFFF, 64'h0006_0001_0001_FFFF, 2'b01, 1'b1, 2'b10, "R5 R6 usat16 sub");
        run_op(64'h0000_0000_0000_0003, 64'h0000_0000_0000_0004, 2'b11, 1'b1, 2'b10, "R5 usat64 sub");
        run_op(64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_0010, 2'b11, 1'b0, 2'b10, "R5 usat64 add");
    endtask

    task automatic t_hold;
        logic [63:0] keep_r;
        logic [7:0]  keep_f;
        run_op(64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, 2'b00, 1'b0, 2'b01, "R7 setup");
        keep_r = result_o;
        keep_f = sat_o;
        @(negedge clk);
        a_i = 64'h1234_5678_9ABC_DEF0; b_i = '1; mode_i = 2'b10; valid_i = 1'b0;
        @(negedge clk);
        check("R7 hold result", result_o, keep_r);
        check("R7 hold flags", {56'd0, sat_o}, {56'd0, keep_f});
        check("R7 valid low", {63'd0, valid_o}, 64'd0);
    endtask

    task automatic t_sweep;
        for (int i = 0; i < 96; i++) begin
            logic [63:0] a, b;
            a = {$urandom(), $urandom()};
            b = {$urandom(), $urandom()};
            if (i % 4 == 0) a = a | 64'h8080_8080_8080_8080;
            run_op(a, b, 2'(i % 4), 1'((i / 4) % 2), 2'((i / 8) % 4), "R1 R2 R4 R5 sweep");
        end
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_wrap_lanes();
        t_subtract();
        t_signed();
        t_unsigned();
        t_hold();
        t_sweep();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule